// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator processor. It takes two byte operands, a working value and a register-file value, plus the processor's present carry bit and a four-bit operation select. In the same cycle, without any clock, it produces the byte result, the new carry, digit carry and zero flags, and one update enable per flag. The enclosing core writes a flag into its status register only when that flag's enable is high. The core also decides where the result goes.

Subtraction always takes the register value minus the working value. For subtraction both carry flags mean "no borrow". Add, subtract, increment and decrement share one adder that is split at the nibble boundary, so the digit carry is the carry out of the low half.

Top module: `acc_alu_top`

## Requirements
- R1: With op_code 0 (add), result = (op_f + op_w) mod 256. c_out is the carry out of bit 7 and dc_out is the carry out of bit 3. All three flag enables are 1.
- R2: With op_code 1 (subtract), result = (op_f - op_w) mod 256. c_out = 1 exactly when op_f >= op_w (no borrow), and dc_out = 1 exactly when op_f[3:0] >= op_w[3:0]. All three flag enables are 1.
- R3: op_code 6 (increment) gives op_f + 1 and op_code 7 (decrement) gives op_f - 1, both wrapping modulo 256 (0xFF+1 = 0x00, 0x00-1 = 0xFF). Only z_upd is set.
- R4: op_code 2 gives op_f AND op_w, 3 gives OR, 4 gives XOR, and 5 gives the bitwise inverse of op_f. Only z_upd is set.
- R5: op_code 8 exchanges the two nibbles of op_f (0xA5 becomes 0x5A) and sets no flag enable.
- R6: op_code 9 rotates op_f left through carry: carry_in enters bit 0 and old bit 7 leaves on c_out. op_code 10 rotates right: carry_in enters bit 7 and old bit 0 leaves on c_out. Only c_upd is set.
- R7: op_code 11 (move) passes op_f unchanged and op_code 12 (clear) gives 0x00. Only z_upd is set.
- R8: Whenever z_upd is 1, z_out is 1 exactly when the result is 0x00.
- R9: A flag whose enable is 0 is driven to a fixed value: c_out = carry_in, dc_out = 0, z_out = 0.
- R10: op_code values 13, 14 and 15 give result 0x00 with all flag enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| op_w | input | 8 | Working (accumulator) operand |
| op_f | input | 8 | Register-file operand |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Operation result |
| c_out | output | 1 | New carry / no-borrow flag |
| dc_out | output | 1 | New digit carry / nibble no-borrow flag |
| z_out | output | 1 | New zero flag |
| c_upd | output | 1 | Carry flag write enable |
| dc_upd | output | 1 | Digit carry flag write enable |
| z_upd | output | 1 | Zero flag write enable |

## Verification
The bench aims at the borrow polarity of subtraction: 0x02 minus 0x34 must give carry 0, and 0x42 minus 0xFF must clear the digit carry while the result is 0x43. A design that took the raw borrow, or subtracted in the wrong order, would invert these flags or produce 0x32 and 0xBD. The bench wraps increment past 0xFF and decrement below 0x00, which catches an adder that drops or sign-extends the carry constant. It rotates values whose edge bits differ from carry_in, so a rotate that ignores the incoming carry or takes the wrong outgoing bit shows up. It also feeds zero operands to swap and rotate: a design that raised the zero enable for those operations would report z_out = 1 there.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_COMP  = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_SWAP  = 4'd8,
        OP_ROTL  = 4'd9,
        OP_ROTR  = 4'd10,
        OP_MOVE  = 4'd11,
        OP_CLEAR = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_ARITH,
        GRP_LOGIC,
        GRP_SHIFT,
        GRP_NONE
    } alu_grp_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flag_s;

    function automatic alu_grp_e op_group(alu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC:                   return GRP_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_COMP,
            OP_SWAP, OP_MOVE, OP_CLEAR:                       return GRP_LOGIC;
            OP_ROTL, OP_ROTR:                                 return GRP_SHIFT;
            default:                                          return GRP_NONE;
        endcase
    endfunction

    function automatic flag_s op_enables(alu_op_e op);
        flag_s en;
        en = '0;
        case (op)
            OP_ADD, OP_SUB:                     en = '{c: 1'b1, dc: 1'b1, z: 1'b1};
            OP_AND, OP_OR, OP_XOR, OP_COMP,
            OP_INC, OP_DEC, OP_MOVE, OP_CLEAR:  en = '{c: 1'b0, dc: 1'b0, z: 1'b1};
            OP_ROTL, OP_ROTR:                   en = '{c: 1'b1, dc: 1'b0, z: 1'b0};
            default:                            en = '0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e              op,
    input  logic [WIDTH-1:0]     w_val,
    input  logic [WIDTH-1:0]     f_val,
    output logic [WIDTH-1:0]     sum,
    output logic                 carry,
    output logic                 half_carry
);
    localparam int NIB = WIDTH / 2;
    localparam int HI  = WIDTH - NIB;

    logic [WIDTH-1:0] b_val;
    logic             c_in;
    logic [NIB:0]     lo_sum;
    logic [HI:0]      hi_sum;

    // Second operand and carry-in chosen so one adder covers four operations;
    // subtraction is F + ~W + 1, so the carries read as "no borrow".
    always_comb begin
        case (op)
            OP_ADD:  begin b_val = w_val;        c_in = 1'b0; end
            OP_SUB:  begin b_val = ~w_val;       c_in = 1'b1; end
            OP_INC:  begin b_val = '0;           c_in = 1'b1; end
            OP_DEC:  begin b_val = '1;           c_in = 1'b0; end
            default: begin b_val = '0;           c_in = 1'b0; end
        endcase
    end

    always_comb begin
        lo_sum = {1'b0, f_val[NIB-1:0]} + {1'b0, b_val[NIB-1:0]} + {{NIB{1'b0}}, c_in};
        hi_sum = {1'b0, f_val[WIDTH-1:NIB]} + {1'b0, b_val[WIDTH-1:NIB]}
               + {{HI{1'b0}}, lo_sum[NIB]};
    end

    assign sum        = {hi_sum[HI-1:0], lo_sum[NIB-1:0]};
    assign carry      = hi_sum[HI];
    assign half_carry = lo_sum[NIB];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e              op,
    input  logic [WIDTH-1:0]     w_val,
    input  logic [WIDTH-1:0]     f_val,
    output logic [WIDTH-1:0]     res
);
    localparam int NIB = WIDTH / 2;

    always_comb begin
        case (op)
            OP_AND:  res = f_val & w_val;
            OP_OR:   res = f_val | w_val;
            OP_XOR:  res = f_val ^ w_val;
            OP_COMP: res = ~f_val;
            OP_SWAP: res = {f_val[NIB-1:0], f_val[WIDTH-1:NIB]};
            OP_MOVE: res = f_val;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e              op,
    input  logic [WIDTH-1:0]     f_val,
    input  logic                 c_in,
    output logic [WIDTH-1:0]     res,
    output logic                 c_new
);
    always_comb begin
        if (op == OP_ROTR) begin
            res   = {c_in, f_val[WIDTH-1:1]};
            c_new = f_val[0];
        end else begin
            res   = {f_val[WIDTH-2:0], c_in};
            c_new = f_val[WIDTH-1];
        end
    end

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] op_w,
    input  logic [WIDTH-1:0] op_f,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             c_out,
    output logic             dc_out,
    output logic             z_out,
    output logic             c_upd,
    output logic             dc_upd,
    output logic             z_upd
);
    alu_op_e          op;
    alu_grp_e         grp;
    flag_s            en;
    logic [WIDTH-1:0] arith_res, logic_res, shift_res;
    logic             arith_c, arith_dc, shift_c;
    logic             c_raw;

    assign op  = alu_op_e'(op_code);
    assign grp = op_group(op);
    assign en  = op_enables(op);

    acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .op         (op),
        .w_val      (op_w),
        .f_val      (op_f),
        .sum        (arith_res),
        .carry      (arith_c),
        .half_carry (arith_dc)
    );

    acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op    (op),
        .w_val (op_w),
        .f_val (op_f),
        .res   (logic_res)
    );

    acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .op    (op),
        .f_val (op_f),
        .c_in  (carry_in),
        .res   (shift_res),
        .c_new (shift_c)
    );

    always_comb begin
        case (grp)
            GRP_ARITH: begin result = arith_res; c_raw = arith_c; end
            GRP_LOGIC: begin result = logic_res; c_raw = carry_in; end
            GRP_SHIFT: begin result = shift_res; c_raw = shift_c; end
            default:   begin result = '0;        c_raw = carry_in; end
        endcase
    end

    assign c_upd  = en.c;
    assign dc_upd = en.dc;
    assign z_upd  = en.z;
    assign c_out  = en.c  ? c_raw    : carry_in;
    assign dc_out = en.dc ? arith_dc : 1'b0;
    assign z_out  = en.z  ? (result == '0) : 1'b0;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic [3:0]       op_code,
    input logic [WIDTH-1:0] op_w,
    input logic [WIDTH-1:0] op_f,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             c_out,
    input logic             dc_out,
    input logic             z_out,
    input logic             c_upd,
    input logic             dc_upd,
    input logic             z_upd
);
    logic [WIDTH:0] add_ref;
    assign add_ref = {1'b0, op_f} + {1'b0, op_w};

    always_comb begin
        // R8
        if (z_upd)
            a_r8_zero_flag: assert (z_out == (result == '0));
        // R9
        if (!c_upd)
            a_r9_carry_hold: assert (c_out == carry_in);
        if (!dc_upd)
            a_r9_dc_quiet: assert (!dc_out);
        // R1
        if (op_code == 4'd0)
            a_r1_add_sum: assert ({c_out, result} == add_ref);
        // R2
        if (op_code == 4'd1)
            a_r2_sub_borrow: assert (c_out == (op_f >= op_w));
        // R5
        if (op_code == 4'd8)
            a_r5_swap_quiet: assert (!c_upd && !dc_upd && !z_upd);
        // R6
        if (op_code == 4'd9)
            a_r6_rotl_carry: assert (c_out == op_f[WIDTH-1] && result[0] == carry_in);
        // R10
        if (op_code > 4'd12)
            a_r10_unused: assert (result == '0 && !c_upd && !dc_upd && !z_upd);
    end

endmodule

bind acc_alu_top acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .op_code  (op_code),
    .op_w     (op_w),
    .op_f     (op_f),
    .carry_in (carry_in),
    .result   (result),
    .c_out    (c_out),
    .dc_out   (dc_out),
    .z_out    (z_out),
    .c_upd    (c_upd),
    .dc_upd   (dc_upd),
    .z_upd    (z_upd)
);

// File: tb/tb_acc_alu_top.sv
module tb_acc_alu_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_code = '0;
    logic [7:0] op_w = '0;
    logic [7:0] op_f = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       c_out, dc_out, z_out, c_upd, dc_upd, z_upd;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    acc_alu_top dut (
        .op_code  (op_code),
        .op_w     (op_w),
        .op_f     (op_f),
        .carry_in (carry_in),
        .result   (result),
        .c_out    (c_out),
        .dc_out   (dc_out),
        .z_out    (z_out),
        .c_upd    (c_upd),
        .dc_upd   (dc_upd),
        .z_upd    (z_upd)
    );

    // drive on the falling edge, sample one ns later
    task automatic run_op(input logic [3:0] op, input logic [7:0] w, input logic [7:0] f,
                          input logic c);
        @(negedge clk);
        op_code  = op;
        op_w     = w;
        op_f     = f;
        carry_in = c;
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [7:0] er, input logic ec,
                              input logic edc, input logic ez, input logic [2:0] eupd);
        n_run++;
        if (result !== er || c_out !== ec || dc_out !== edc || z_out !== ez ||
            {c_upd, dc_upd, z_upd} !== eupd) begin
            n_fail++;
            $display("FAIL %s: got res=%02h c=%b dc=%b z=%b upd=%b%b%b, expected res=%02h c=%b dc=%b z=%b upd=%03b",
                     tag, result, c_out, dc_out, z_out, c_upd, dc_upd, z_upd,
                     er, ec, edc, ez, eupd);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        run_op(4'd0, 8'h00, 8'h00, 1'b0);
        expect_out("R1 R8 idle inputs", 8'h00, 1'b0, 1'b0, 1'b1, 3'b111);
    endtask

    task automatic t_add();
        run_op(4'd0, 8'hE1, 8'h23, 1'b0);
        expect_out("R1 add carry out", 8'h04, 1'b1, 1'b0, 1'b0, 3'b111);
        run_op(4'd0, 8'h0F, 8'h34, 1'b1);
        expect_out("R1 add digit carry", 8'h43, 1'b0, 1'b1, 1'b0, 3'b111);
        run_op(4'd0, 8'h80, 8'h80, 1'b0);
        expect_out("R1 R8 add to zero", 8'h00, 1'b1, 1'b0, 1'b1, 3'b111);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] w, f;
            logic [8:0] s;
            w = 8'(i * 37 + 5);
            f = 8'(i * 91 + 200);
            s = {1'b0, f} + {1'b0, w};
            run_op(4'd0, w, f, 1'b0);
            expect_out("R1 add sweep", s[7:0], s[8],
                       (({1'b0, f[3:0]} + {1'b0, w[3:0]}) > 5'd15), (s[7:0] == 8'h00), 3'b111);
        end
    endtask

    task automatic t_sub();
        run_op(4'd1, 8'h02, 8'h04, 1'b0);
        expect_out("R2 sub no borrow", 8'h02, 1'b1, 1'b1, 1'b0, 3'b111);
        run_op(4'd1, 8'h34, 8'h02, 1'b1);
        expect_out("R2 sub borrow", 8'hCE, 1'b0, 1'b0, 1'b0, 3'b111);
        run_op(4'd1, 8'h01, 8'h43, 1'b0);
        expect_out("R2 sub nibble ok", 8'h42, 1'b1, 1'b1, 1'b0, 3'b111);
        run_op(4'd1, 8'hFF, 8'h42, 1'b1);
        expect_out("R2 sub nibble borrow", 8'h43, 1'b0, 1'b0, 1'b0, 3'b111);
        run_op(4'd1, 8'h55, 8'h55, 1'b0);
        expect_out("R2 R8 sub equal", 8'h00, 1'b1, 1'b1, 1'b1, 3'b111);
    endtask

    task automatic t_incdec();
        run_op(4'd6, 8'h00, 8'hFF, 1'b1);
        expect_out("R3 R9 inc wrap", 8'h00, 1'b1, 1'b0, 1'b1, 3'b001);
        run_op(4'd7, 8'h00, 8'h00, 1'b0);
        expect_out("R3 dec wrap", 8'hFF, 1'b0, 1'b0, 1'b0, 3'b001);
        run_op(4'd7, 8'h00, 8'h01, 1'b1);
        expect_out("R3 dec to zero", 8'h00, 1'b1, 1'b0, 1'b1, 3'b001);
    endtask

    task automatic t_logic();
        run_op(4'd2, 8'hF0, 8'h5A, 1'b0);
        expect_out("R4 and", 8'h50, 1'b0, 1'b0, 1'b0, 3'b001);
        run_op(4'd3, 8'hA5, 8'h00, 1'b1);
        expect_out("R4 or", 8'hA5, 1'b1, 1'b0, 1'b0, 3'b001);
        run_op(4'd4, 8'h5A, 8'hAF, 1'b0);
        expect_out("R4 xor", 8'hF5, 1'b0, 1'b0, 1'b0, 3'b001);
        run_op(4'd5, 8'h00, 8'h50, 1'b0);
        expect_out("R4 complement", 8'hAF, 1'b0, 1'b0, 1'b0, 3'b001);
        run_op(4'd2, 8'hF0, 8'h0F, 1'b0);
        expect_out("R4 R8 and zero", 8'h00, 1'b0, 1'b0, 1'b1, 3'b001);
    endtask

    task automatic t_swap();
        run_op(4'd8, 8'h00, 8'hA5, 1'b1);
        expect_out("R5 swap", 8'h5A, 1'b1, 1'b0, 1'b0, 3'b000);
        run_op(4'd8, 8'hFF, 8'h00, 1'b0);
        expect_out("R5 R9 swap zero no z", 8'h00, 1'b0, 1'b0, 1'b0, 3'b000);
    endtask

    task automatic t_rotate();
        run_op(4'd9, 8'h00, 8'h81, 1'b0);
        expect_out("R6 rotl out", 8'h02, 1'b1, 1'b0, 1'b0, 3'b100);
        run_op(4'd9, 8'h00, 8'h40, 1'b1);
        expect_out("R6 rotl in", 8'h81, 1'b0, 1'b0, 1'b0, 3'b100);
        run_op(4'd10, 8'h00, 8'h01, 1'b1);
        expect_out("R6 rotr", 8'h80, 1'b1, 1'b0, 1'b0, 3'b100);
        run_op(4'd10, 8'h00, 8'h00, 1'b0);
        expect_out("R6 R9 rotr zero no z", 8'h00, 1'b0, 1'b0, 1'b0, 3'b100);
    endtask

    task automatic t_move_clear();
        run_op(4'd11, 8'hC3, 8'h3C, 1'b0);
        expect_out("R7 move", 8'h3C, 1'b0, 1'b0, 1'b0, 3'b001);
        run_op(4'd11, 8'hC3, 8'h00, 1'b1);
        expect_out("R7 R8 move zero", 8'h00, 1'b1, 1'b0, 1'b1, 3'b001);
        run_op(4'd12, 8'hFF, 8'h77, 1'b0);
        expect_out("R7 clear", 8'h00, 1'b0, 1'b0, 1'b1, 3'b001);
    endtask

    task automatic t_unused();
        for (int k = 13; k < 16; k++) begin
            run_op(4'(k), 8'hFF, 8'hFF, 1'b1);
            expect_out("R10 unused code", 8'h00, 1'b1, 1'b0, 1'b0, 3'b000);
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_incdec();
        t_logic();
        t_swap();
        t_rotate();
        t_move_clear();
        t_unused();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule